// File: doc/BRIEF.md
# Line Bus Activity Detector

This block decides whether signalling frames are present on a received line by watching the stream of decoded line bits. Each bit arrives with a one-cycle strobe. A zero bit stands for a line pulse and a one bit for a quiet bit period. The block raises a registered activity flag when a few zero bits arrive close together. It drops the flag only after a long unbroken run of ones.

The set rule and the clear rule are deliberately different, so the flag has asymmetric hysteresis. By default, three zeros inside a 48-bit span set the flag, which is roughly 250 microseconds of line time. Clearing takes 128 consecutive ones. All spans are counted in bit strobes, never in clock cycles, so the clock may run at any rate above the bit rate. A span opens at the first zero seen while the flag is low. If the span runs out before enough zeros arrive, counting starts over at the next zero.

Top module: `line_activity_detect`

## Requirements
- R1: While the flag is low, the ZERO_COUNT-th zero bit received within WINDOW_BITS strobes sets the flag. The span counts from and includes the first zero. The flag is visible at the output in the cycle after the strobe that carried that zero.
- R2: Clock cycles with the strobe low change nothing: they do not advance any span and do not change the flag, whatever value the bit input carries.
- R3: A zero that arrives WINDOW_BITS or more strobes after the first zero of the current span does not count toward that span. It opens a fresh span as its first zero.
- R4: While the flag is high, ONES_CLEAR consecutive one bits clear it, and any zero bit restarts that run from nothing. The flag reads low in the cycle after the strobe of the final one.
- R5: While the flag is high, zero bits never clear it and leave no zero count behind for the next low period.
- R6: Synchronous reset clears the flag and every counter. After reset, a full ZERO_COUNT zeros are needed again to set the flag.
- R7: No counter exceeds its limit or wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | One-cycle strobe marking a received line bit |
| bit_in | input | 1 | Received bit; 0 means a line pulse |
| active | output | 1 | Registered bus activity flag |

## Verification
The bench builds the block with ZERO_COUNT=3, WINDOW_BITS=8 and ONES_CLEAR=6. With these values, every 12-bit pattern applied after reset can both open a span and let it expire. Each pattern can also set the flag and clear it again. This makes an exhaustive sweep of 4096 patterns reach span expiry at the exact boundary bit, zeros arriving while the flag is set, and complete clear runs. Idle strobe-low cycles with a zero on the bit input are mixed into part of the sweep. Directed sequences cover a reset while the flag is set and an interrupted run of ones.

// File: rtl/line_activity_pkg.sv
package line_activity_pkg;
    typedef enum logic {
        SPAN_IDLE = 1'b0,
        SPAN_OPEN = 1'b1
    } span_state_e;
endpackage

// File: rtl/zero_span_counter.sv
module zero_span_counter
    import line_activity_pkg::*;
#(
    parameter int ZERO_COUNT  = 3,
    parameter int WINDOW_BITS = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    output logic set_o
);
    localparam int ZC_W = $clog2(ZERO_COUNT + 1);
    localparam int SP_W = $clog2(WINDOW_BITS + 1);

    typedef struct packed {
        span_state_e     st;
        logic [ZC_W-1:0] zeros;
        logic [SP_W-1:0] span;
    } span_t;

    localparam span_t SPAN_RST = '{st: SPAN_IDLE, zeros: '0, span: '0};

    span_t span_d, span_q;
    logic [ZC_W-1:0] zeros_inc;
    logic [SP_W-1:0] span_inc;

    always_comb begin
        span_d    = span_q;
        set_o     = 1'b0;
        zeros_inc = span_q.zeros + 1'b1;
        span_inc  = span_q.span + 1'b1;
        if (active_i) begin
            span_d = SPAN_RST;
        end else if (bit_vld_i) begin
            case (span_q.st)
                SPAN_IDLE: begin
                    if (!bit_i) begin
                        if (ZERO_COUNT <= 1) begin
                            set_o = 1'b1;
                        end else begin
                            span_d.st    = SPAN_OPEN;
                            span_d.zeros = ZC_W'(1);
                            span_d.span  = SP_W'(1);
                        end
                    end
                end
                default: begin
                    if (!bit_i && zeros_inc >= ZC_W'(ZERO_COUNT)) begin
                        set_o  = 1'b1;
                        span_d = SPAN_RST;
                    end else if (span_inc >= SP_W'(WINDOW_BITS)) begin
                        span_d = SPAN_RST;
                    end else begin
                        span_d.span = span_inc;
                        if (!bit_i) begin
                            span_d.zeros = zeros_inc;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            span_q <= SPAN_RST;
        end else begin
            span_q <= span_d;
        end
    end

    assert_zeros_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        span_q.zeros < ZC_W'(ZERO_COUNT));
    assert_span_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        span_q.span < SP_W'(WINDOW_BITS));
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld_i && !active_i) |=> $stable(span_q));
    assert_high_clears_R5: assert property (@(posedge clk) disable iff (rst)
        active_i |=> (span_q.st == SPAN_IDLE && span_q.zeros == '0));
endmodule

// File: rtl/ones_run_counter.sv
module ones_run_counter #(
    parameter int ONES_CLEAR = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    output logic clr_o
);
    localparam int ON_W = $clog2(ONES_CLEAR + 1);

    typedef struct packed {
        logic [ON_W-1:0] ones;
    } run_t;

    run_t run_d, run_q;
    logic [ON_W-1:0] ones_inc;

    always_comb begin
        run_d    = run_q;
        clr_o    = 1'b0;
        ones_inc = run_q.ones + 1'b1;
        if (!active_i) begin
            run_d.ones = '0;
        end else if (bit_vld_i) begin
            if (!bit_i) begin
                run_d.ones = '0;
            end else if (ones_inc >= ON_W'(ONES_CLEAR)) begin
                clr_o      = 1'b1;
                run_d.ones = '0;
            end else begin
                run_d.ones = ones_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assert_ones_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        run_q.ones < ON_W'(ONES_CLEAR));
    assert_zero_restarts_R4: assert property (@(posedge clk) disable iff (rst)
        (active_i && bit_vld_i && !bit_i) |=> (run_q.ones == '0));
endmodule

// File: rtl/line_activity_detect.sv
module line_activity_detect #(
    parameter int ZERO_COUNT  = 3,
    parameter int WINDOW_BITS = 48,
    parameter int ONES_CLEAR  = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic active
);
    typedef struct packed {
        logic flag;
    } top_t;

    top_t top_d, top_q;
    logic set_hit;
    logic clr_hit;

    zero_span_counter #(
        .ZERO_COUNT (ZERO_COUNT),
        .WINDOW_BITS(WINDOW_BITS)
    ) u_zero_span (
        .clk      (clk),
        .rst      (rst),
        .active_i (top_q.flag),
        .bit_vld_i(bit_vld),
        .bit_i    (bit_in),
        .set_o    (set_hit)
    );

    ones_run_counter #(
        .ONES_CLEAR(ONES_CLEAR)
    ) u_ones_run (
        .clk      (clk),
        .rst      (rst),
        .active_i (top_q.flag),
        .bit_vld_i(bit_vld),
        .bit_i    (bit_in),
        .clr_o    (clr_hit)
    );

    always_comb begin
        top_d = top_q;
        if (set_hit) begin
            top_d.flag = 1'b1;
        end else if (clr_hit) begin
            top_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign active = top_q.flag;

    assert_set_needs_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (!active && !(bit_vld && !bit_in)) |=> !active);
    assert_clear_needs_one_R5: assert property (@(posedge clk) disable iff (rst)
        (active && !(bit_vld && bit_in)) |=> active);
    assert_hits_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(set_hit && clr_hit));
endmodule

// File: tb/line_activity_detect_test.sv
`timescale 1ns/1ps
module line_activity_detect_test;
    localparam int ZC = 3;
    localparam int WB = 8;
    localparam int OC = 6;
    localparam int NB = 12;

    logic clk = 1'b0;
    logic rst;
    logic bit_vld;
    logic bit_in;
    logic active;

    int errors = 0;
    int checks = 0;

    bit m_flag;
    bit m_open;
    int m_start;
    int m_zeros;
    int m_ones;
    int m_idx;

    always #2 clk = ~clk;

    line_activity_detect #(
        .ZERO_COUNT (ZC),
        .WINDOW_BITS(WB),
        .ONES_CLEAR (OC)
    ) uut (
        .clk    (clk),
        .rst    (rst),
        .bit_vld(bit_vld),
        .bit_in (bit_in),
        .active (active)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: active=%0b expected %0b (bit %0d)", tag, got, exp, m_idx);
        end
    endtask

    task automatic model_reset();
        m_flag = 0; m_open = 0; m_start = 0; m_zeros = 0; m_ones = 0; m_idx = 0;
    endtask

    task automatic model_step(input bit b);
        if (!m_flag) begin
            if (m_open && (m_idx - m_start) >= WB) m_open = 0;
            if (!b) begin
                if (!m_open) begin
                    m_open = 1; m_start = m_idx; m_zeros = 1;
                end else begin
                    m_zeros++;
                end
                if (m_zeros >= ZC) begin
                    m_flag = 1; m_open = 0; m_ones = 0;
                end
            end
        end else begin
            if (!b) begin
                m_ones = 0;
            end else begin
                m_ones++;
                if (m_ones >= OC) begin
                    m_flag = 0; m_ones = 0;
                end
            end
        end
        m_idx++;
    endtask

    task automatic do_reset();
        rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R6", active, 1'b0);
    endtask

    task automatic send(input bit b);
        bit prev;
        string tag;
        prev = m_flag;
        bit_vld = 1'b1;
        bit_in = b;
        model_step(b);
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in = 1'b1;
        if (!prev && m_flag) tag = "R1";
        else if (prev && !m_flag) tag = "R4";
        else if (prev) tag = "R5";
        else tag = "R3";
        check(tag, active, m_flag);
    endtask

    task automatic idle(input int n);
        bit_in = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R2", active, m_flag);
        end
        bit_in = 1'b1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b1;
        model_reset();
        @(negedge clk);
        do_reset();

        // Exhaustive 12-bit sweep: R1, R3, R4, R5, with strobe-low gaps for R2
        for (int p = 0; p < (1 << NB); p++) begin
            do_reset();
            for (int i = 0; i < NB; i++) begin
                send(p[i]);
                if ((p % 4) == 1) idle(1);
            end
        end

        // R2: long strobe-low stretch with a zero on the input never sets
        do_reset();
        idle(20);
        send(1'b0);
        idle(10);
        send(1'b0);
        check("R2", active, 1'b0);

        // R6: reset while set, then two zeros must not set
        do_reset();
        send(1'b0); send(1'b0); send(1'b0);
        check("R1", active, 1'b1);
        do_reset();
        send(1'b0); send(1'b0);
        check("R6", active, 1'b0);
        send(1'b0);
        check("R6", active, 1'b1);

        // R4: run of ones broken by a zero restarts
        for (int k = 0; k < OC - 1; k++) send(1'b1);
        send(1'b0);
        for (int k = 0; k < OC - 1; k++) send(1'b1);
        check("R4", active, 1'b1);
        send(1'b1);
        check("R4", active, 1'b0);

        // R5: a zero-only burst while set leaves no count behind
        send(1'b0); send(1'b0); send(1'b0);
        send(1'b0); send(1'b0);
        for (int k = 0; k < OC; k++) send(1'b1);
        check("R5", active, 1'b0);
        send(1'b0); send(1'b0);
        check("R5", active, 1'b0);

        summary();
        $finish;
    end
endmodule